// File: doc/BRIEF.md
# Gated Input-Following Tracker

This block is a two-input sequential machine with an output bit `z` and one auxiliary bit `q`. While the gate input `b_in` is high, `z` copies every transition of the data input `a_in`. While `b_in` is low, transitions of `a_in` are ignored. When `b_in` rises, `z` does not jump to the current level of `a_in`. It keeps its value until `a_in` makes its next transition. The auxiliary bit keeps apart total states that would otherwise need contradictory next states. For example, "z low, waiting for a rise" and "z low, idle" must be separate states.

The behaviour is modelled as a set of asynchronous transitions, with one settling step for each clock tick. On every rising clock edge the state `{z, q}` takes the next-state value computed from the current inputs and the current state. A state whose next-state value equals itself is stable, and the block flags this on `stable_out`. Every next-state value differs from its present state in at most one bit. Every unstable state reaches a stable one in a single step.

Top module: `gated_follow_tracker`

## Requirements
- R1: The active-low asynchronous reset forces the state to `{z_out, q_out}` = 00. With both inputs low, `stable_out` is then 1.
- R2: With `b_in` high and state 01, a rise of `a_in` produces state 11 (`z_out`=1) one clock later. A rise of `z_out` only ever follows a cycle in which `a_in` was high.
- R3: With `b_in` high and state 11, a fall of `a_in` produces state 01 (`z_out`=0) one clock later. A fall of `z_out` only ever follows a cycle in which `a_in` was low and `b_in` high.
- R4: While `b_in` stays low, `z_out` keeps its value whatever `a_in` does. Lowering `b_in` in state 01 with `a_in` low gives state 00. Lowering `a_in` in state 11 with `b_in` low gives state 10. States 00, 10 and 11 are stable with `a_in` high and `b_in` low.
- R5: Raising `b_in` never moves `z_out` by itself. State 00 is stable with both inputs high. State 10 is stable with `a_in` low and `b_in` high.
- R6: From state 00 with both inputs high, lowering `a_in` gives state 01. A following rise of `a_in` then makes `z_out` 1.
- R7: The otherwise unreachable total state (a=1, b=0, state 01) steps to state 11 and is stable there. It is entered when both inputs change in the same cycle.
- R8: On any clock edge outside reset, at most one of `z_out`, `q_out` changes. When `stable_out` is 0, the state changes on the next edge.
- R9: `stable_out` is 1 exactly when the next-state value equals the present state. While it is 1 and the inputs are held, the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one settling step per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 1 | Data input whose transitions are followed |
| b_in | input | 1 | Gate input; following is enabled while high |
| z_out | output | 1 | Output state bit |
| q_out | output | 1 | Auxiliary state bit |
| stable_out | output | 1 | High when the present state is its own next state |

## Verification
The assertions check on every cycle the properties that hold for any input history. These are: single-bit steps, settling within one edge of an unstable flag, the state holding while stable, `z_out` holding across consecutive gate-low cycles, and the input conditions that must precede each rise or fall of `z_out`. What a given input sequence should produce can only be shown by the bench's scenarios. This covers the exact target state of each transition, the refusal to jump when the gate rises, the collision-avoiding route through state 01, and the entry into the unassigned state when both inputs move at once.

// File: rtl/gft_pkg.sv
package gft_pkg;

  localparam int STATE_W = 2;

  typedef struct packed {
    logic z;
    logic q;
  } gft_state_t;

  localparam gft_state_t RESET_STATE = '{z: 1'b0, q: 1'b0};

  // Two-level next-state equations of the transition map.
  function automatic gft_state_t gft_next(input logic a, input logic b,
                                          input gft_state_t s);
    gft_state_t n;
    n.z = (a & (s.z | s.q)) | (~a & s.z & (~b | ~s.q));
    n.q = (~a & b & (~s.z | s.q)) | (a & b & (s.z | s.q)) | (a & ~b & s.q);
    return n;
  endfunction

  // A state is stable when it is its own successor.
  function automatic logic gft_is_stable(input gft_state_t cur,
                                         input gft_state_t nxt);
    return (cur == nxt);
  endfunction

endpackage

// File: rtl/gft_next_logic.sv
module gft_next_logic
  import gft_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  gft_state_t cur_i,
  output gft_state_t nxt_o,
  output logic       stable_o
);

  always_comb begin
    nxt_o    = gft_next(a_i, b_i, cur_i);
    stable_o = gft_is_stable(cur_i, nxt_o);
  end

endmodule

// File: rtl/gft_state_reg.sv
module gft_state_reg
  import gft_pkg::*;
#(
  parameter gft_state_t INIT = RESET_STATE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  gft_state_t nxt_i,
  output gft_state_t cur_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_o <= INIT;
    else        cur_o <= nxt_i;
  end

endmodule

// File: rtl/gated_follow_tracker.sv
module gated_follow_tracker
  import gft_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_in,
  input  logic b_in,
  output logic z_out,
  output logic q_out,
  output logic stable_out
);

  gft_state_t cur_s;
  gft_state_t nxt_s;
  logic       stable_w;

  // Named internal events, visible to the checker.
  logic [STATE_W-1:0] step_diff_w;
  logic               z_will_rise_w;
  logic               z_will_fall_w;

  gft_next_logic u_next (
    .a_i      (a_in),
    .b_i      (b_in),
    .cur_i    (cur_s),
    .nxt_o    (nxt_s),
    .stable_o (stable_w)
  );

  gft_state_reg #(.INIT(RESET_STATE)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt_i (nxt_s),
    .cur_o (cur_s)
  );

  assign step_diff_w   = cur_s ^ nxt_s;
  assign z_will_rise_w = ~cur_s.z & nxt_s.z;
  assign z_will_fall_w = cur_s.z & ~nxt_s.z;

  assign z_out      = cur_s.z;
  assign q_out      = cur_s.q;
  assign stable_out = stable_w;

endmodule

// File: rtl/gft_checker.sv
module gft_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       a_in,
  input logic       b_in,
  input logic       z_out,
  input logic       q_out,
  input logic       stable_out,
  input logic [1:0] step_diff_w,
  input logic       z_will_rise_w,
  input logic       z_will_fall_w
);

  // R8: at most one state bit moves per edge
  p_single_bit_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({z_out, q_out} ^ $past({z_out, q_out})) <= 1);

  // R8: a pending step is at most one bit wide
  p_pending_step_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step_diff_w) <= 1);

  // R8: an unstable state moves on the next edge
  p_unstable_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stable_out |=> ({z_out, q_out} != $past({z_out, q_out})));

  // R9: a stable state holds
  p_stable_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stable_out |=> $stable({z_out, q_out}));

  // R4: gate low on two consecutive edges keeps z
  p_gate_low_holds_z_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_in && $past(!b_in)) |=> $stable(z_out));

  // R2: z rises only after a cycle with a high
  p_rise_needs_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(z_out) |-> $past(a_in));

  // R3: z falls only after a cycle with a low and b high
  p_fall_needs_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(z_out) |-> $past(!a_in && b_in));

  // R2/R3: announced z events appear at the output
  p_rise_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    z_will_rise_w |=> z_out);
  p_fall_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    z_will_fall_w |=> !z_out);

endmodule

bind gated_follow_tracker gft_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .a_in          (a_in),
  .b_in          (b_in),
  .z_out         (z_out),
  .q_out         (q_out),
  .stable_out    (stable_out),
  .step_diff_w   (step_diff_w),
  .z_will_rise_w (z_will_rise_w),
  .z_will_fall_w (z_will_fall_w)
);

// File: tb/gated_follow_tracker_tb_top.sv
module gated_follow_tracker_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_in = 1'b0;
  logic b_in = 1'b0;
  logic z_out, q_out, stable_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  gated_follow_tracker dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_in       (a_in),
    .b_in       (b_in),
    .z_out      (z_out),
    .q_out      (q_out),
    .stable_out (stable_out)
  );

  // Entry: {a, b, stable before edge, z after, q after, stable after}
  localparam int NV = 21;
  localparam logic [5:0] VEC [NV] = '{
    6'b010011, 6'b110111, 6'b010011, 6'b000001, 6'b101001, 6'b111001,
    6'b010011, 6'b110111, 6'b101111, 6'b000101, 6'b011101, 6'b110111,
    6'b010011, 6'b100111, 6'b000101, 6'b101101, 6'b001101, 6'b110111,
    6'b000101, 6'b011101, 6'b001101
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 1, 7, 11: return "R2";
      2, 12:       return "R3";
      3, 8, 9, 14, 15, 16, 20: return "R4";
      4, 5, 10, 19: return "R5";
      6:           return "R6";
      13:          return "R7";
      default:     return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "reset zq/stable", {z_out, q_out, stable_out}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "after release", {z_out, q_out, stable_out}, 3'b001);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      a_in = VEC[i][5];
      b_in = VEC[i][4];
      #1;
      check("R9", $sformatf("vec %0d stable before edge", i),
            {2'b00, stable_out}, {2'b00, VEC[i][3]});
      @(negedge clk);
      check(vec_req(i), $sformatf("vec %0d z/q/stable", i),
            {z_out, q_out, stable_out}, VEC[i][2:0]);
    end

    // R9: hold inputs, state and flag do not move (state 10, AB=00)
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R9", "held inputs", {z_out, q_out, stable_out}, 3'b101);
    end

    // R4: toggle a with b low from z=1
    for (int k = 0; k < 4; k++) begin
      a_in = ~a_in;
      @(negedge clk);
      check("R4", "a toggles, b low, z=1", {z_out, 2'b00}, 3'b100);
    end

    // R1: reset during operation from z=1
    rst_n = 1'b0;
    a_in = 1'b0;
    b_in = 1'b0;
    #1;
    check("R1", "async reset mid-run", {z_out, q_out, stable_out}, 3'b001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: toggle a with b low from z=0
    for (int k = 0; k < 4; k++) begin
      a_in = ~a_in;
      @(negedge clk);
      check("R4", "a toggles, b low, z=0", {z_out, q_out, 1'b0}, 3'b000);
    end

    // R5 then R2: gate rises with a low, z stays, next a rise follows
    a_in = 1'b0;
    @(negedge clk);
    b_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R5", "gate rise, a low", {z_out, q_out, stable_out}, 3'b011);
    a_in = 1'b1;
    @(negedge clk);
    check("R2", "a rise with gate high", {z_out, q_out, stable_out}, 3'b111);

    finish_run();
  end

endmodule